// File: doc/BRIEF.md
# Serial Port Host Register Block

This block sits between a byte-wide host bus and the data path of an asynchronous serial port. The host selects one of eight byte locations with a 3-bit address and a read or write strobe. The block holds the frame format, FIFO setup, modem-control outputs, interrupt mask and a scratch byte. It turns accesses to the data location into push and pop strobes for the transmit and receive FIFOs. It gathers the receiver's error events into a status byte whose error bits stay set until read.

The block also contains the programmable rate divider. A 16-bit divisor is stored in two bytes. The host reaches those bytes by setting an access bit in the frame-format register, which switches locations 0 and 1 from their normal roles to the divisor bytes. The divider gives a one-cycle enable pulse every divisor clock cycles, at sixteen times the serial bit rate. For example, a divisor of 30 on an 18.432 MHz clock gives 38,400 bit/s. All strobes and register writes act on the host strobe cycle. Reads return data in that same cycle, from a combinational path.

Top module: `sio_host_regs`

## Requirements
- R1: After reset, the frame-format, FIFO-setup, interrupt-mask, modem-control and scratch registers read 0. The divisor reads 1 (low byte 1, high byte 0), so `tick16` pulses on every cycle.
- R2: Scratch (address 7) and frame format (address 3) read back the written byte. The interrupt mask (address 1, access bit clear) keeps bits 3:0 and reads 0 above them. Modem control (address 4) keeps bits 4:0, drives them on `modem_ctl`, and reads 0 above them.
- R3: While bit 7 of the frame-format register is 1, addresses 0 and 1 read and write the divisor's low and high bytes. In that state, accesses to them raise neither `tx_push` nor `rx_pop`.
- R4: With the access bit clear, a write to address 0 raises `tx_push` in that cycle with `tx_byte` equal to the written byte. A read of address 0 raises `rx_pop` in that cycle and returns `rx_byte`.
- R5: `tick16` pulses once every D cycles, where D is the divisor, and a divisor of 0 acts as 1. A write to either divisor byte restarts the count, so the first pulse falls D cycles after the write edge.
- R6: The frame-format fields drive the outputs by bit position: bits 1:0 give `word_bits`, bit 2 `two_stop`, bit 3 `parity_on`, bit 4 `parity_even`, bit 5 `parity_stick` and bit 6 `break_on`.
- R7: A write to address 2 stores bit 0 as `fifo_on`, bit 3 as `dma_sel` and bits 7:6 as the receive threshold. `rx_trig_bytes` shows the threshold as 1, 4, 8 or 14 for codes 00, 01, 10 and 11.
- R8: Bits 1 and 2 of a write to address 2 pulse `rx_fifo_clr` and `tx_fifo_clr` in the write cycle only. Neither bit is stored.
- R9: The line status byte at address 5 holds these bits: 7 FIFO error (`rx_fifo_err` while `fifo_on`), 6 transmitter idle, 5 holding empty, 4 break, 3 framing, 2 parity, 1 overrun, 0 data ready. Bits 4:1 are set by one-cycle event inputs and clear after a read of address 5. An event in the same cycle as that read survives the read.
- R10: Address 2 reads `{fifo_on, fifo_on, 2'b00, 4'b0001}`, and address 6 returns `modem_stat` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| tx_push | output | 1 | Push to transmit FIFO |
| tx_byte | output | 8 | Byte to push |
| rx_pop | output | 1 | Pop from receive FIFO |
| rx_byte | input | 8 | Head of receive FIFO |
| rx_fifo_clr | output | 1 | Receive FIFO clear pulse |
| tx_fifo_clr | output | 1 | Transmit FIFO clear pulse |
| fifo_on | output | 1 | FIFO mode enabled |
| dma_sel | output | 1 | DMA mode select |
| rx_trig_bytes | output | 5 | Receive threshold in bytes |
| word_bits | output | 2 | Data length code (00 = 5 bits, 11 = 8 bits) |
| two_stop | output | 1 | Extended stop select |
| parity_on | output | 1 | Parity enabled |
| parity_even | output | 1 | Even parity select |
| parity_stick | output | 1 | Fixed-value parity select |
| break_on | output | 1 | Hold line low |
| intr_mask | output | 4 | Interrupt enable bits |
| modem_ctl | output | 5 | Modem control bits |
| rx_ready | input | 1 | Receive data available |
| rx_ovr_evt | input | 1 | Overrun event |
| rx_par_evt | input | 1 | Parity error event |
| rx_frm_evt | input | 1 | Framing error event |
| rx_brk_evt | input | 1 | Break event |
| rx_fifo_err | input | 1 | Error present in receive FIFO |
| tx_hold_empty | input | 1 | Transmit holding empty |
| tx_idle | input | 1 | Transmitter fully idle |
| modem_stat | input | 8 | Modem status placeholder |
| tick16 | output | 1 | Enable pulse at 16x bit rate |

## Verification
The hardest case to reach is an error event that arrives in the same cycle as the status read that clears the error bits. The read must return the old value and the new event must still be there on the next read. The stimulus drives an event input on exactly the cycle of a status-read strobe, then reads status twice more. The divider phase after a divisor change is also hard to see from the ports. A behavioural counter in the bench follows every divisor write and checks `tick16` on every cycle, including after a divisor of 0.

// File: rtl/sio_regs_pkg.sv
package sio_regs_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int DIV_W  = 2 * DATA_W;
    localparam int IEN_W  = 4;
    localparam int MCTL_W = 5;
    localparam int TRIG_W = 5;

    typedef enum logic [ADDR_W-1:0] {
        LOC_DATA  = 3'd0,
        LOC_IEN   = 3'd1,
        LOC_FIFO  = 3'd2,
        LOC_LINE  = 3'd3,
        LOC_MODEM = 3'd4,
        LOC_LSTAT = 3'd5,
        LOC_MSTAT = 3'd6,
        LOC_SCR   = 3'd7
    } loc_e;

    // frame format register, MSB first
    typedef struct packed {
        logic       dlab;
        logic       brk;
        logic       stick;
        logic       even;
        logic       pen;
        logic       stop2;
        logic [1:0] wlen;
    } line_ctl_t;

    typedef struct packed {
        logic [1:0] trig;
        logic       dma;
        logic       en;
    } fifo_ctl_t;

    typedef struct packed {
        logic fifo_err;
        logic temt;
        logic thre;
        logic bi;
        logic fe;
        logic pe;
        logic oe;
        logic dr;
    } line_stat_t;

    typedef struct packed {
        logic wr_thr;
        logic wr_dll;
        logic wr_dlm;
        logic wr_ien;
        logic wr_fifo;
        logic wr_line;
        logic wr_modem;
        logic wr_scr;
        logic rd_rbr;
        logic rd_lstat;
    } strobe_t;

    function automatic logic [TRIG_W-1:0] trig_to_bytes(input logic [1:0] code);
        case (code)
            2'b00:   return TRIG_W'(1);
            2'b01:   return TRIG_W'(4);
            2'b10:   return TRIG_W'(8);
            default: return TRIG_W'(14);
        endcase
    endfunction

endpackage

// File: rtl/sio_addr_decode.sv
module sio_addr_decode
    import sio_regs_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              dlab,
    output strobe_t           stb
);
    always_comb begin
        stb = '0;
        if (wr_en) begin
            case (loc_e'(addr))
                LOC_DATA:  begin stb.wr_thr = !dlab; stb.wr_dll = dlab; end
                LOC_IEN:   begin stb.wr_ien = !dlab; stb.wr_dlm = dlab; end
                LOC_FIFO:  stb.wr_fifo  = 1'b1;
                LOC_LINE:  stb.wr_line  = 1'b1;
                LOC_MODEM: stb.wr_modem = 1'b1;
                LOC_SCR:   stb.wr_scr   = 1'b1;
                default:   ;
            endcase
        end
        if (rd_en) begin
            stb.rd_rbr   = (loc_e'(addr) == LOC_DATA) && !dlab;
            stb.rd_lstat = (loc_e'(addr) == LOC_LSTAT);
        end
    end
endmodule

// File: rtl/sio_ctl_regs.sv
module sio_ctl_regs
    import sio_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  strobe_t           stb,
    input  logic [DATA_W-1:0] wdata,
    output line_ctl_t         line_q,
    output fifo_ctl_t         fifo_q,
    output logic [IEN_W-1:0]  ien_q,
    output logic [MCTL_W-1:0] mctl_q,
    output logic [DATA_W-1:0] scr_q,
    output logic [DIV_W-1:0]  div_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
            fifo_q <= '0;
            ien_q  <= '0;
            mctl_q <= '0;
            scr_q  <= '0;
            div_q  <= DIV_W'(1);
        end else begin
            if (stb.wr_line)  line_q <= line_ctl_t'(wdata);
            if (stb.wr_fifo)  fifo_q <= '{trig: wdata[7:6], dma: wdata[3], en: wdata[0]};
            if (stb.wr_ien)   ien_q  <= wdata[IEN_W-1:0];
            if (stb.wr_modem) mctl_q <= wdata[MCTL_W-1:0];
            if (stb.wr_scr)   scr_q  <= wdata;
            if (stb.wr_dll)   div_q[DATA_W-1:0]     <= wdata;
            if (stb.wr_dlm)   div_q[DIV_W-1:DATA_W] <= wdata;
        end
    end
endmodule

// File: rtl/sio_line_status.sv
module sio_line_status
    import sio_regs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       ev_oe,
    input  logic       ev_pe,
    input  logic       ev_fe,
    input  logic       ev_bi,
    input  logic       live_dr,
    input  logic       live_thre,
    input  logic       live_temt,
    input  logic       live_ferr,
    output line_stat_t stat
);
    logic [3:0] sticky_q;
    logic [3:0] events;

    assign events = {ev_bi, ev_fe, ev_pe, ev_oe};

    // new events win over a clearing read in the same cycle
    always_ff @(posedge clk) begin
        if (rst) sticky_q <= '0;
        else     sticky_q <= (clr ? 4'b0000 : sticky_q) | events;
    end

    always_comb begin
        stat          = '0;
        stat.fifo_err = live_ferr;
        stat.temt     = live_temt;
        stat.thre     = live_thre;
        stat.bi       = sticky_q[3];
        stat.fe       = sticky_q[2];
        stat.pe       = sticky_q[1];
        stat.oe       = sticky_q[0];
        stat.dr       = live_dr;
    end
endmodule

// File: rtl/sio_baud_gen.sv
module sio_baud_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] eff;

    assign eff  = (divisor == '0) ? ONE : divisor;
    assign tick = (cnt_q >= eff - ONE);

    always_ff @(posedge clk) begin
        if (rst || restart) cnt_q <= '0;
        else if (tick)      cnt_q <= '0;
        else                cnt_q <= cnt_q + ONE;
    end
endmodule

// File: rtl/sio_host_regs.sv
module sio_host_regs
    import sio_regs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  addr,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        tx_push,
    output logic [7:0]  tx_byte,
    output logic        rx_pop,
    input  logic [7:0]  rx_byte,
    output logic        rx_fifo_clr,
    output logic        tx_fifo_clr,
    output logic        fifo_on,
    output logic        dma_sel,
    output logic [4:0]  rx_trig_bytes,
    output logic [1:0]  word_bits,
    output logic        two_stop,
    output logic        parity_on,
    output logic        parity_even,
    output logic        parity_stick,
    output logic        break_on,
    output logic [3:0]  intr_mask,
    output logic [4:0]  modem_ctl,
    input  logic        rx_ready,
    input  logic        rx_ovr_evt,
    input  logic        rx_par_evt,
    input  logic        rx_frm_evt,
    input  logic        rx_brk_evt,
    input  logic        rx_fifo_err,
    input  logic        tx_hold_empty,
    input  logic        tx_idle,
    input  logic [7:0]  modem_stat,
    output logic        tick16
);
    strobe_t           stb;
    line_ctl_t         lcr_q;
    fifo_ctl_t         fcr_q;
    logic [IEN_W-1:0]  ien_q;
    logic [MCTL_W-1:0] mcr_q;
    logic [DATA_W-1:0] scr_q;
    logic [DIV_W-1:0]  div_q;
    line_stat_t        lsr_q;

    sio_addr_decode i_dec (
        .addr  (addr),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .dlab  (lcr_q.dlab),
        .stb   (stb)
    );

    sio_ctl_regs i_regs (
        .clk    (clk),
        .rst    (rst),
        .stb    (stb),
        .wdata  (wdata),
        .line_q (lcr_q),
        .fifo_q (fcr_q),
        .ien_q  (ien_q),
        .mctl_q (mcr_q),
        .scr_q  (scr_q),
        .div_q  (div_q)
    );

    sio_line_status i_lsr (
        .clk       (clk),
        .rst       (rst),
        .clr       (stb.rd_lstat),
        .ev_oe     (rx_ovr_evt),
        .ev_pe     (rx_par_evt),
        .ev_fe     (rx_frm_evt),
        .ev_bi     (rx_brk_evt),
        .live_dr   (rx_ready),
        .live_thre (tx_hold_empty),
        .live_temt (tx_idle),
        .live_ferr (rx_fifo_err && fcr_q.en),
        .stat      (lsr_q)
    );

    sio_baud_gen #(.DIV_W(DIV_W)) i_baud (
        .clk     (clk),
        .rst     (rst),
        .restart (stb.wr_dll || stb.wr_dlm),
        .divisor (div_q),
        .tick    (tick16)
    );

    // FIFO path strobes
    assign tx_push     = stb.wr_thr;
    assign tx_byte     = wdata;
    assign rx_pop      = stb.rd_rbr;
    assign rx_fifo_clr = stb.wr_fifo && wdata[1];
    assign tx_fifo_clr = stb.wr_fifo && wdata[2];

    // configuration fields
    assign fifo_on       = fcr_q.en;
    assign dma_sel       = fcr_q.dma;
    assign rx_trig_bytes = trig_to_bytes(fcr_q.trig);
    assign word_bits     = lcr_q.wlen;
    assign two_stop      = lcr_q.stop2;
    assign parity_on     = lcr_q.pen;
    assign parity_even   = lcr_q.even;
    assign parity_stick  = lcr_q.stick;
    assign break_on      = lcr_q.brk;
    assign intr_mask     = ien_q;
    assign modem_ctl     = mcr_q;

    always_comb begin
        case (loc_e'(addr))
            LOC_DATA:  rdata = lcr_q.dlab ? div_q[DATA_W-1:0] : rx_byte;
            LOC_IEN:   rdata = lcr_q.dlab ? div_q[DIV_W-1:DATA_W]
                                          : {{(DATA_W-IEN_W){1'b0}}, ien_q};
            LOC_FIFO:  rdata = {fcr_q.en, fcr_q.en, 2'b00, 4'b0001};
            LOC_LINE:  rdata = lcr_q;
            LOC_MODEM: rdata = {{(DATA_W-MCTL_W){1'b0}}, mcr_q};
            LOC_LSTAT: rdata = lsr_q;
            LOC_MSTAT: rdata = modem_stat;
            default:   rdata = scr_q;
        endcase
    end
endmodule

// File: rtl/sio_host_regs_chk.sv
module sio_host_regs_chk
    import sio_regs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              tx_push,
    input logic              rx_pop,
    input line_ctl_t         lcr_q,
    input logic [DIV_W-1:0]  div_q,
    input line_stat_t        lsr_q,
    input logic              rx_ovr_evt,
    input logic              rx_brk_evt,
    input logic              tick16
);
    logic [DIV_W-1:0] since_q;
    logic [DIV_W-1:0] eff_div;
    logic             div_wr;

    assign eff_div = (div_q == '0) ? DIV_W'(1) : div_q;
    assign div_wr  = wr_en && lcr_q.dlab && (addr <= 3'd1);

    always_ff @(posedge clk) begin
        if (rst || tick16 || div_wr) since_q <= '0;
        else                         since_q <= since_q + DIV_W'(1);
    end

    // R3: the access bit blocks FIFO strobes
    a_r3_no_push_in_dlab: assert property (@(posedge clk) disable iff (rst)
        (tx_push || rx_pop) |-> !lcr_q.dlab);

    // R3: divisor low byte takes the written value
    a_r3_div_low_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 3'd0 && lcr_q.dlab) |=> (div_q[DATA_W-1:0] == $past(wdata)));

    // R5: pulse spacing follows the divisor
    a_r5_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        tick16 |-> (since_q == eff_div - DIV_W'(1)));

    // R9: overrun event is captured
    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        rx_ovr_evt |=> lsr_q.oe);

    // R9: break event is captured
    a_r9_break_sticky: assert property (@(posedge clk) disable iff (rst)
        rx_brk_evt |=> lsr_q.bi);
endmodule

bind sio_host_regs sio_host_regs_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .tx_push    (tx_push),
    .rx_pop     (rx_pop),
    .lcr_q      (lcr_q),
    .div_q      (div_q),
    .lsr_q      (lsr_q),
    .rx_ovr_evt (rx_ovr_evt),
    .rx_brk_evt (rx_brk_evt),
    .tick16     (tick16)
);

// File: tb/test_sio_host_regs.sv
module test_sio_host_regs;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0, rdata;
    logic       tx_push, rx_pop, rx_fifo_clr, tx_fifo_clr;
    logic [7:0] tx_byte;
    logic [7:0] rx_byte = '0;
    logic       fifo_on, dma_sel;
    logic [4:0] rx_trig_bytes;
    logic [1:0] word_bits;
    logic       two_stop, parity_on, parity_even, parity_stick, break_on;
    logic [3:0] intr_mask;
    logic [4:0] modem_ctl;
    logic       rx_ready = 0, rx_ovr_evt = 0, rx_par_evt = 0, rx_frm_evt = 0, rx_brk_evt = 0;
    logic       rx_fifo_err = 0, tx_hold_empty = 0, tx_idle = 0;
    logic [7:0] modem_stat = '0;
    logic       tick16;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // behavioural reference for the rate divider
    int m_div = 1;
    int m_cnt = 0;
    bit m_dlab = 0;

    sio_host_regs i_sio_host_regs (.*);

    always #10 clk = ~clk;

    task automatic check(input string req, input int got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    always @(posedge clk) begin
        int eff;
        eff = (m_div == 0) ? 1 : m_div;
        if (rst) begin
            m_div = 1; m_cnt = 0; m_dlab = 0;
        end else begin
            if (wr_en && m_dlab && addr == 3'd0) begin
                m_div = (m_div & 'hFF00) | wdata; m_cnt = 0;
            end else if (wr_en && m_dlab && addr == 3'd1) begin
                m_div = (m_div & 'h00FF) | (int'(wdata) << 8); m_cnt = 0;
            end else if (m_cnt + 1 >= eff) m_cnt = 0;
            else m_cnt = m_cnt + 1;
            if (wr_en && addr == 3'd3) m_dlab = wdata[7];
        end
    end

    always @(negedge clk) begin
        int eff;
        if (!rst && !done) begin
            eff = (m_div == 0) ? 1 : m_div;
            check("R5 tick16", tick16, (m_cnt >= eff - 1) ? 1 : 0);
        end
    end

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] v);
        addr = a; rd_en = 1'b1;
        #2 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got 1 expected 0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        bus_read(3'd3, v); check("R1 line", v, 0);
        bus_read(3'd7, v); check("R1 scratch", v, 0);
        bus_read(3'd1, v); check("R1 ien", v, 0);
        bus_read(3'd4, v); check("R1 modem", v, 0);
        check("R1 fifo_on", fifo_on, 0);
        check("R1 trig", rx_trig_bytes, 1);
        repeat (3) @(negedge clk);
        bus_write(3'd3, 8'h80);
        bus_read(3'd0, v); check("R1 div lo", v, 1);
        bus_read(3'd1, v); check("R1 div hi", v, 0);

        // R3 divisor access, no FIFO strobes
        addr = 3'd0; wdata = 8'h05; wr_en = 1'b1;
        #2 check("R3 no push", tx_push, 0);
        @(negedge clk); wr_en = 1'b0;
        bus_write(3'd1, 8'h00);
        addr = 3'd0; rd_en = 1'b1; rx_byte = 8'h77;
        #2 check("R3 no pop", rx_pop, 0); check("R3 div lo", rdata, 5);
        @(negedge clk); rd_en = 1'b0;
        repeat (17) @(negedge clk);   // R5 period 5

        // R2 and R6
        bus_write(3'd3, 8'h3B);
        bus_read(3'd3, v); check("R2 line", v, 8'h3B);
        check("R6 word_bits", word_bits, 3);
        check("R6 two_stop", two_stop, 0);
        check("R6 parity_on", parity_on, 1);
        check("R6 parity_even", parity_even, 1);
        check("R6 parity_stick", parity_stick, 1);
        check("R6 break_on", break_on, 0);
        bus_write(3'd3, 8'h44);
        check("R6 break_on", break_on, 1);
        check("R6 two_stop", two_stop, 1);
        bus_write(3'd7, 8'hA5);
        bus_read(3'd7, v); check("R2 scratch", v, 8'hA5);
        bus_write(3'd1, 8'hFF);
        bus_read(3'd1, v); check("R2 ien", v, 8'h0F);
        check("R2 intr_mask", intr_mask, 4'hF);
        bus_write(3'd4, 8'hFF);
        bus_read(3'd4, v); check("R2 modem", v, 8'h1F);
        check("R2 modem_ctl", modem_ctl, 5'h1F);

        // R4 data path with access bit clear
        addr = 3'd0; wdata = 8'h3C; wr_en = 1'b1;
        #2 check("R4 push", tx_push, 1); check("R4 tx_byte", tx_byte, 8'h3C);
        @(negedge clk); wr_en = 1'b0;
        #2 check("R4 push low", tx_push, 0);
        addr = 3'd0; rd_en = 1'b1; rx_byte = 8'hC3;
        #2 check("R4 pop", rx_pop, 1); check("R4 rx_byte", rdata, 8'hC3);
        @(negedge clk); rd_en = 1'b0;
        bus_read(3'd7, v); check("R2 scratch kept", v, 8'hA5);

        // R5 divisor 0 acts as 1, then divisor 3
        bus_write(3'd3, 8'h80);
        bus_write(3'd0, 8'h00);
        repeat (4) @(negedge clk);
        bus_write(3'd0, 8'h03);
        repeat (10) @(negedge clk);
        bus_write(3'd3, 8'h00);

        // R7 and R8
        addr = 3'd2; wdata = 8'hC9; wr_en = 1'b1;
        #2 check("R8 rx clr idle", rx_fifo_clr, 0); check("R8 tx clr idle", tx_fifo_clr, 0);
        @(negedge clk); wr_en = 1'b0;
        check("R7 fifo_on", fifo_on, 1);
        check("R7 dma", dma_sel, 1);
        check("R7 trig14", rx_trig_bytes, 14);
        bus_read(3'd2, v); check("R10 ident on", v, 8'hC1);
        bus_write(3'd2, 8'h41);
        check("R7 trig4", rx_trig_bytes, 4);
        bus_write(3'd2, 8'h81);
        check("R7 trig8", rx_trig_bytes, 8);
        addr = 3'd2; wdata = 8'h06; wr_en = 1'b1;
        #2 check("R8 rx clr", rx_fifo_clr, 1); check("R8 tx clr", tx_fifo_clr, 1);
        @(negedge clk); wr_en = 1'b0;
        #2 check("R8 rx clr gone", rx_fifo_clr, 0); check("R8 tx clr gone", tx_fifo_clr, 0);
        check("R7 fifo off", fifo_on, 0);
        check("R7 trig1", rx_trig_bytes, 1);
        bus_read(3'd2, v); check("R10 ident off", v, 8'h01);

        // R9 line status
        rx_ready = 1; tx_hold_empty = 1; tx_idle = 0; rx_fifo_err = 1;
        bus_read(3'd5, v); check("R9 live bits", v, 8'h21);
        rx_ovr_evt = 1; @(negedge clk); rx_ovr_evt = 0;
        bus_read(3'd5, v); check("R9 overrun set", v, 8'h23);
        bus_read(3'd5, v); check("R9 overrun cleared", v, 8'h21);
        rx_frm_evt = 1; rx_brk_evt = 1; @(negedge clk); rx_frm_evt = 0; rx_brk_evt = 0;
        addr = 3'd5; rd_en = 1'b1; rx_par_evt = 1;
        #2 check("R9 read with event", rdata, 8'h39);
        @(negedge clk); rd_en = 1'b0; rx_par_evt = 0;
        bus_read(3'd5, v); check("R9 event survives", v, 8'h25);
        bus_write(3'd2, 8'h01);
        bus_read(3'd5, v); check("R9 fifo err", v, 8'hA1);

        // R10 modem status passthrough
        modem_stat = 8'h5A;
        bus_read(3'd6, v); check("R10 modem status", v, 8'h5A);

        // R1 reset again restores divisor 1
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        bus_read(3'd7, v); check("R1 scratch reset", v, 0);
        repeat (3) @(negedge clk);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule